// File: doc/BRIEF.md
# Timer Output Compare Channel with Forced Compare

This block is a single output compare channel for a 16-bit timer. Each cycle it compares the timer's count with a compare value. A real match is an equal count while counting is enabled. On a real match the channel changes its output pin as the 2-bit pin-action code selects. It also raises a sticky match flag and, when clear-on-match mode is active, asks the timer to restart from zero.

A force strobe lets software trigger the pin action at once, without waiting for a match. A forced compare acts on the pin in exactly the way a match would. It never touches the flag or the counter-clear request. While a PWM waveform mode is selected, the force strobe has no effect, and this unit also leaves the pin alone on real matches, because PWM shaping lives outside the block.

All three outputs are registered. Their effect appears on the first clock edge after the cycle in which the inputs that caused it were present.

Top module: `ocu_channel`

## Requirements
- R1: While rst_n is low, and right after it is released, pin_out, match_flag and cnt_clear are all 0.
- R2: A real match (count_en=1 and count_val equal to cmp_val) sets match_flag at the next clock edge. The flag then stays 1 until it is cleared.
- R3: When flag_clr is 1 in a cycle with no real match, match_flag is 0 after the next edge. If a real match occurs in the same cycle, the flag is set instead.
- R4: When ctc_mode=1, a real match makes cnt_clear 1 for exactly the following cycle. In every other case cnt_clear is 0.
- R5: With pwm_mode=0, a compare action (a real match or a force) updates pin_out at the next edge as out_mode selects: 2'b00 holds the level, 2'b01 inverts it, 2'b10 drives 0, 2'b11 drives 1.
- R6: With pwm_mode=0, force_stb=1 performs the R5 pin action at the next edge, even when the count is not equal to the compare value.
- R7: A force never sets match_flag and never raises cnt_clear, including when ctc_mode=1.
- R8: With pwm_mode=1, pin_out does not change. This holds for both forces and real matches, and the flag still follows real matches.
- R9: A force and a real match in the same cycle apply the pin action once (with 2'b01 the pin inverts a single time). The flag and cnt_clear still follow the match.
- R10: With count_en=0, an equal count_val and cmp_val is not a match: no flag, no cnt_clear and no pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Timer counts this cycle; qualifies matches |
| count_val | input | 16 | Current timer count |
| cmp_val | input | 16 | Compare value |
| out_mode | input | 2 | Pin action code (see R5) |
| pwm_mode | input | 1 | A PWM waveform mode is selected |
| ctc_mode | input | 1 | Clear-on-match mode using this channel as top |
| force_stb | input | 1 | One-cycle forced compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| pin_out | output | 1 | Output pin level |
| match_flag | output | 1 | Sticky compare-match interrupt flag |
| cnt_clear | output | 1 | Request to clear the timer counter |

## Verification
Every result (the pin level, the flag and the clear request) is due exactly one clock edge after the input cycle that causes it. There is no multi-cycle latency anywhere in the block. The bench drives each input set on a falling edge and lets one rising edge pass. On the next falling edge it advances its behavioural model by one step and compares all three outputs. Directed sequences cover each pin action, forces in both mode classes, coincident force and match, and the flag set/clear race. A long run of random inputs with compare values from a small range then makes matches frequent.

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [CNT_W-1:0] count_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       out_mode,
  input  logic             pwm_mode,
  input  logic             ctc_mode,
  input  logic             force_stb,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             match_flag,
  output logic             cnt_clear
);

  logic hit;
  logic act;
  logic pin_nxt;

  assign hit = count_en && (count_val == cmp_val);
  assign act = !pwm_mode && (hit || force_stb);

  always_comb begin
    case (out_mode)
      2'b01:   pin_nxt = ~pin_out;
      2'b10:   pin_nxt = 1'b0;
      2'b11:   pin_nxt = 1'b1;
      default: pin_nxt = pin_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out    <= 1'b0;
      match_flag <= 1'b0;
      cnt_clear  <= 1'b0;
    end else begin
      if (act) pin_out <= pin_nxt;
      if (hit) match_flag <= 1'b1;
      else if (flag_clr) match_flag <= 1'b0;
      cnt_clear <= hit && ctc_mode;
    end
  end

endmodule

module ocu_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_en,
  input logic [CNT_W-1:0] count_val,
  input logic [CNT_W-1:0] cmp_val,
  input logic [1:0]       out_mode,
  input logic             pwm_mode,
  input logic             ctc_mode,
  input logic             force_stb,
  input logic             flag_clr,
  input logic             pin_out,
  input logic             match_flag,
  input logic             cnt_clear
);

  a_r2_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && count_val == cmp_val) |=> match_flag);

  a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(count_en && count_val == cmp_val)) |=> !match_flag);

  a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc_mode && count_en && count_val == cmp_val) |=> cnt_clear);

  a_r7_no_clear_without_match: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_en && count_val == cmp_val) |=> !cnt_clear);

  a_r7_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && !(count_en && count_val == cmp_val)) |=> !match_flag);

  a_r8_pwm_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> $stable(pin_out));

  a_r5_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |=> $stable(pin_out));

  a_r6_force_set: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !pwm_mode && out_mode == 2'b11) |=> pin_out);

endmodule

bind ocu_channel ocu_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .count_val(count_val),
  .cmp_val(cmp_val), .out_mode(out_mode), .pwm_mode(pwm_mode),
  .ctc_mode(ctc_mode), .force_stb(force_stb), .flag_clr(flag_clr),
  .pin_out(pin_out), .match_flag(match_flag), .cnt_clear(cnt_clear)
);

// File: tb/ocu_channel_tb.sv
module ocu_channel_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic count_en = 1'b0;
  logic [W-1:0] count_val = '0;
  logic [W-1:0] cmp_val = '0;
  logic [1:0] out_mode = 2'b00;
  logic pwm_mode = 1'b0;
  logic ctc_mode = 1'b0;
  logic force_stb = 1'b0;
  logic flag_clr = 1'b0;
  logic pin_out, match_flag, cnt_clear;

  int checks = 0;
  int failures = 0;
  bit m_pin = 0, m_flag = 0, m_clr = 0;

  always #(CLK_P/2) clk = ~clk;

  ocu_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .count_val(count_val),
    .cmp_val(cmp_val), .out_mode(out_mode), .pwm_mode(pwm_mode),
    .ctc_mode(ctc_mode), .force_stb(force_stb), .flag_clr(flag_clr),
    .pin_out(pin_out), .match_flag(match_flag), .cnt_clear(cnt_clear)
  );

  task automatic chk(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, advance model, compare all outputs.
  task automatic step(input string req, input bit en, input int cv, input int mv,
                      input bit [1:0] md, input bit pwm, input bit ctc,
                      input bit frc, input bit clr);
    bit match, doit;
    count_en = en; count_val = W'(cv); cmp_val = W'(mv); out_mode = md;
    pwm_mode = pwm; ctc_mode = ctc; force_stb = frc; flag_clr = clr;
    match = en && (cv == mv);
    doit = !pwm && (match || frc);
    @(posedge clk);
    if (doit) begin
      if (md == 2'b01) m_pin = !m_pin;
      else if (md == 2'b10) m_pin = 0;
      else if (md == 2'b11) m_pin = 1;
    end
    if (match) m_flag = 1;
    else if (clr) m_flag = 0;
    m_clr = match && ctc;
    @(negedge clk);
    chk(req, "pin_out", pin_out, m_pin);
    chk(req, "match_flag", match_flag, m_flag);
    chk(req, "cnt_clear", cnt_clear, m_clr);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "pin_out in reset", pin_out, 0);
    chk("R1", "match_flag in reset", match_flag, 0);
    chk("R1", "cnt_clear in reset", cnt_clear, 0);
    rst_n = 1'b1;
    step("R1", 0, 1, 2, 2'b00, 0, 0, 0, 0);
    // R6 / R5: force each code, no match
    step("R6", 0, 1, 2, 2'b11, 0, 0, 1, 0);
    step("R5", 0, 1, 2, 2'b00, 0, 0, 1, 0);
    step("R5", 0, 1, 2, 2'b01, 0, 0, 1, 0);
    step("R5", 0, 1, 2, 2'b01, 0, 0, 1, 0);
    step("R5", 0, 1, 2, 2'b10, 0, 0, 1, 0);
    // R7: force in CTC gives no flag, no clear
    step("R7", 1, 1, 2, 2'b11, 0, 1, 1, 0);
    step("R7", 0, 5, 5, 2'b01, 0, 1, 1, 0);
    // R10: equal but not counting
    step("R10", 0, 7, 7, 2'b01, 0, 1, 0, 0);
    // R2 / R4: real match in CTC, then flag sticks, clear pulses once
    step("R4", 1, 7, 7, 2'b01, 0, 1, 0, 0);
    step("R2", 1, 8, 7, 2'b01, 0, 1, 0, 0);
    step("R2", 1, 9, 7, 2'b00, 0, 0, 0, 0);
    // R3: clear flag; then clear racing a match
    step("R3", 1, 9, 7, 2'b00, 0, 0, 0, 1);
    step("R3", 1, 7, 7, 2'b00, 0, 0, 0, 1);
    step("R3", 0, 7, 7, 2'b00, 0, 0, 0, 1);
    // R9: force and match together, toggle once
    step("R9", 1, 3, 3, 2'b01, 0, 1, 1, 0);
    step("R9", 1, 3, 3, 2'b01, 0, 0, 1, 1);
    step("R3", 0, 3, 3, 2'b00, 0, 0, 0, 1);
    // R8: PWM mode blocks pin changes, flag still follows match
    step("R8", 0, 0, 1, 2'b01, 1, 0, 1, 0);
    step("R8", 0, 0, 1, 2'b11, 1, 0, 1, 0);
    step("R8", 1, 4, 4, 2'b01, 1, 0, 1, 0);
    step("R8", 1, 4, 4, 2'b10, 1, 0, 0, 0);
    // Random phase checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      step("R2", bit'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
           2'($urandom_range(0, 3)), $urandom_range(0, 5) == 0, bit'($urandom_range(0, 1)),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule